// File: doc/BRIEF.md
# Hardware Mutex Bank

This block is a bank of hardware mutex flags on a simple memory-mapped register bus. Several processors that share that bus use it to coordinate ownership of shared resources. Each flag sits in its own 32-bit register. A bus read of a flag register tests the flag and claims it in the same transaction. The read returns 0 when the caller has just won the flag and 1 when another agent already holds it. The owner gives the flag back by writing zero to the same register.

The number of flags is a build-time parameter: 32, 64, 128 or 256. A read-only status word tells software how many flags exist. It does this with a one-hot multiplier of 32 in its top byte. The bus has a byte address, read and write strobes, write data, read data and a ready pulse. Every access completes one cycle after its strobe.

Top module: `hw_mutex_bank`

## Requirements
- R1: After reset every flag is free, `bus_ready` is 0 and `bus_rdata` is 0.
- R2: Flag number i lives at byte address 0x800 + 4*i. A read there returns 0 and marks the flag taken when it was free. It returns 1 and leaves the flag unchanged when it was already taken.
- R3: A write of the value 0 to a flag register frees that flag.
- R4: A write of any nonzero value to a flag register has no effect. A write to the status word or to an unmapped address also has no effect.
- R5: A read of byte address 0x14 returns NUM_LOCKS/32 in bits 31:24 and 0 in all other bits. That field value is one-hot: 1, 2, 4 or 8.
- R6: A read of an unmapped address returns 0 and changes no flag. Unmapped addresses include any misaligned address and any flag slot at or beyond NUM_LOCKS.
- R7: An access in cycle n gives `bus_ready` = 1 and valid `bus_rdata` in cycle n+1. In a cycle after a cycle with no strobe, `bus_ready` and `bus_rdata` are both 0.
- R8: When `bus_rd` and `bus_wr` are asserted together, only the read takes effect and the write is dropped.
- R9: When the same flag is read in consecutive cycles, only the first read returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Byte address |
| bus_rd | input | 1 | Read strobe; a read of a flag register also claims the flag |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while bus_ready is 1 |
| bus_ready | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the bank with NUM_LOCKS = 64 and ADDR_W = 12. With those values the status field is 2, so a check against bit 25 shows that the count is derived from the parameter and not fixed at the smallest size. The size also puts the last flag, 63, at 0x8FC. The first slot past the bank, 0x900, lies inside the decoded window, so the bench can probe the edge between the last real flag and the unmapped space on both sides. Random traffic is aimed mostly at a handful of flags, so contention, repeated claims and mixed read-write strobes come up often.

// File: rtl/hw_mutex_bank.sv
module hw_mutex_bank #(
  parameter int NUM_LOCKS = 32,
  parameter int ADDR_W    = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              bus_ready
);
  localparam int                IDX_W    = $clog2(NUM_LOCKS);
  localparam logic [ADDR_W-1:0] STAT_OFS = ADDR_W'('h14);
  localparam logic [ADDR_W-1:0] LOCK_OFS = ADDR_W'('h800);
  localparam logic [ADDR_W-1:0] LOCK_SPAN = ADDR_W'(NUM_LOCKS * 4);
  localparam logic [7:0]        CNT_FIELD = 8'(NUM_LOCKS / 32);

  logic [NUM_LOCKS-1:0] taken;
  logic [ADDR_W-1:0]    rel;
  logic [IDX_W-1:0]     idx;
  logic                 hit_lock, hit_stat;

  assign rel      = bus_addr - LOCK_OFS;
  assign idx      = rel[IDX_W+1:2];
  assign hit_lock = (bus_addr >= LOCK_OFS) && (rel < LOCK_SPAN) && (rel[1:0] == 2'b00);
  assign hit_stat = (bus_addr == STAT_OFS);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      taken     <= '0;
      bus_ready <= 1'b0;
      bus_rdata <= '0;
    end else begin
      bus_ready <= bus_rd | bus_wr;
      bus_rdata <= '0;
      if (bus_rd) begin
        if (hit_lock) begin
          bus_rdata  <= {31'b0, taken[idx]};
          taken[idx] <= 1'b1;
        end else if (hit_stat) begin
          bus_rdata <= {CNT_FIELD, 24'b0};
        end
      end else if (bus_wr && hit_lock && (bus_wdata == 32'b0)) begin
        taken[idx] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/hw_mutex_bank_chk.sv
module hw_mutex_bank_chk #(
  parameter int NUM_LOCKS = 32,
  parameter int ADDR_W    = 12
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [ADDR_W-1:0]    bus_addr,
  input logic                 bus_rd,
  input logic                 bus_wr,
  input logic [31:0]          bus_wdata,
  input logic [31:0]          bus_rdata,
  input logic                 bus_ready,
  input logic [NUM_LOCKS-1:0] taken
);
  localparam int IDX_W = $clog2(NUM_LOCKS);

  int          slot;
  logic        on_lock;
  logic [IDX_W-1:0] cur_i, q_i;

  assign slot    = (int'(bus_addr) - 'h800) / 4;
  assign on_lock = (int'(bus_addr) >= 'h800) && (bus_addr[1:0] == 2'b00) && (slot < NUM_LOCKS);
  assign cur_i   = IDX_W'(slot);

  always_ff @(posedge clk) q_i <= cur_i;

  // R7
  ready_after_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd || bus_wr) |=> bus_ready);
  // R7
  quiet_after_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_rd || bus_wr) |=> (!bus_ready && bus_rdata == 32'b0));
  // R2
  claim_marks_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && on_lock) |=> taken[q_i]);
  // R2
  lock_read_binary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && on_lock) |=> (bus_rdata[31:1] == 31'b0));
  // R3
  release_frees_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !bus_rd && on_lock && bus_wdata == 32'b0) |=> !taken[q_i]);
  // R4
  nonzero_write_inert_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !bus_rd && bus_wdata != 32'b0) |=> $stable(taken));
  // R5
  status_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == ADDR_W'('h14)) |=> (bus_rdata == (32'(NUM_LOCKS / 32) << 24)));
  // R5
  status_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_ready && bus_rdata[23:0] == 24'b0) |-> $onehot0(bus_rdata[31:24]));
  // R6
  unmapped_inert_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!on_lock) |=> $stable(taken));
endmodule

bind hw_mutex_bank hw_mutex_bank_chk #(.NUM_LOCKS(NUM_LOCKS), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ready(bus_ready), .taken(taken)
);

// File: tb/tb_hw_mutex_bank.sv
`timescale 1ns/1ps
module tb_hw_mutex_bank;
  localparam int N  = 64;
  localparam int AW = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic          bus_rd = 1'b0, bus_wr = 1'b0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic          bus_ready;

  int  n_checks = 0, n_fail = 0;
  bit  done = 0;
  bit  model [N];

  always #2.5 clk = ~clk;

  hw_mutex_bank #(.NUM_LOCKS(N), .ADDR_W(AW)) dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ready(bus_ready)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Drive at a negedge, sample at the following negedge (one register stage).
  task automatic access(bit rd, bit wr, int a, logic [31:0] d, string tag);
    logic [31:0] exp = 0;
    bit is_lock = (a >= 'h800) && (a < 'h800 + 4*N) && (a % 4 == 0);
    int i = (a - 'h800) / 4;
    if (rd) begin
      if (is_lock) begin exp = 32'(model[i]); model[i] = 1; end
      else if (a == 'h14) exp = 32'(N/32) << 24;
    end else if (wr && is_lock && d == 0) model[i] = 0;
    bus_rd = rd; bus_wr = wr; bus_addr = AW'(a); bus_wdata = d;
    @(negedge clk);
    check({tag, " ready"}, 32'(bus_ready), 32'(rd | wr));
    check({tag, " rdata"}, bus_rdata, exp);
  endtask

  task automatic idle(string tag);
    bus_rd = 0; bus_wr = 0;
    @(negedge clk);
    check({tag, " idle ready"}, 32'(bus_ready), 0);
    check({tag, " idle rdata"}, bus_rdata, 0);
  endtask

  function automatic int lock_addr(int i);
    return 'h800 + 4*i;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    foreach (model[k]) model[k] = 0;
    repeat (3) @(negedge clk);
    // R1
    check("R1 reset ready", 32'(bus_ready), 0);
    check("R1 reset rdata", bus_rdata, 0);
    rst_n = 1;
    @(negedge clk);
    // R1: every flag free after reset, probed at both ends
    access(1, 0, lock_addr(0),  0, "R1 R2 first lock");
    access(1, 0, lock_addr(N-1), 0, "R1 R2 last lock");
    // R9: consecutive reads of the same flag
    access(1, 0, lock_addr(5), 0, "R9 first read");
    access(1, 0, lock_addr(5), 0, "R9 second read");
    idle("R7");
    // R4: nonzero write ignored, then re-read shows still taken
    access(0, 1, lock_addr(5), 32'h1, "R4 nonzero write");
    access(1, 0, lock_addr(5), 0, "R4 still taken");
    // R3: release then reclaim
    access(0, 1, lock_addr(5), 0, "R3 release");
    access(1, 0, lock_addr(5), 0, "R3 reclaim");
    // R5
    access(1, 0, 'h14, 0, "R5 status");
    access(0, 1, 'h14, 0, "R4 status write");
    access(1, 0, 'h14, 0, "R5 status again");
    // R6: past-the-end slot, misaligned, low space; then flag 10 stays free
    access(1, 0, lock_addr(N), 0, "R6 beyond end");
    access(1, 0, lock_addr(10) + 1, 0, "R6 misaligned");
    access(1, 0, 'h10, 0, "R6 low unmapped");
    access(0, 1, lock_addr(10) + 2, 0, "R4 misaligned write");
    access(1, 0, lock_addr(10), 0, "R6 flag untouched");
    // R8: read and write together on a taken flag keeps it taken
    access(1, 1, lock_addr(10), 0, "R8 both strobes");
    access(1, 0, lock_addr(10), 0, "R8 still taken");
    idle("R7");
    // random traffic vs reference model
    for (int k = 0; k < 3000; k++) begin
      int sel = $urandom_range(0, 9);
      int li  = ($urandom_range(0, 4) == 0) ? N-1 : $urandom_range(0, 7);
      case (sel)
        0, 1, 2: access(1, 0, lock_addr(li), 0, "R2 R9 random read");
        3, 4:    access(0, 1, lock_addr(li), 0, "R3 random release");
        5:       access(0, 1, lock_addr(li), $urandom_range(1, 255), "R4 random nonzero");
        6:       access(1, 1, lock_addr(li), 0, "R8 random both");
        7:       access(1, 0, 'h14, 0, "R5 random status");
        8:       access($urandom_range(0, 1), 1, lock_addr(N + li), 0, "R6 random unmapped");
        default: idle("R7 random");
      endcase
    end
    idle("R7 final");
    for (int k = 0; k < N; k++) access(1, 0, lock_addr(k), 0, "R2 final sweep");
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule